// File: doc/BRIEF.md
# Masked Associative Search Array

This block is a small content-addressable memory. Each entry stores a 64-bit word and a two-bit type tag. A comparand register is compared with every entry at once. The search result gives a hit flag, a multiple-hit flag and the lowest matching address. The block also reports, at all times, whether any Empty slot is left and where the lowest one is.

Two mask registers are available, and control fields choose how each one is used. A selected mask can make comparand bits don't-cares during a search. A selected mask can also protect destination bits during a write. The compared field of each word can be narrowed to 48, 32 or 16 bits, and the uncompared part can sit at either end of the word.

A search runs automatically when the comparand, either mask or the control word is loaded. An automatic search looks only at Valid entries. A forced search looks only at entries of one tag chosen by the command. Writes go to three kinds of target: an absolute address, the lowest free slot, or the address of the last hit.

Top module: `cam_assoc`

## Requirements
- R1: While `rst` is high, and after it falls, every entry reads back as data 0 with tag Empty. `hit`, `multi_hit` and `hit_addr` are 0, `full` is 0 and `free_addr` is 0. The comparand, both masks and the control word are cleared.
- R2: Tags are encoded as 0 Empty, 1 Valid, 2 Skip and 3 RAM. An automatic search counts only entries whose tag is Valid.
- R3: Command 5 is a forced search. It counts only entries whose tag equals `op_tag`, whatever that tag is.
- R4: Control bits [4:3] choose the compare mask: 1 selects mask 1, 2 selects mask 2, and 0 or 3 selects no mask. A 1 in the selected mask makes that comparand bit a don't-care for every entry.
- R5: Control bits [1:0] give k, the number of 16-bit segments left out of the compare. The compare uses 64-16k bits. Control bit 2 = 0 compares bits [63-16k:0]. Control bit 2 = 1 compares bits [63:16k].
- R6: `hit` is 1 when at least one entry qualifies. `multi_hit` is 1 when more than one qualifies. `hit_addr` is the lowest qualifying index, or 0 when there is none.
- R7: The search result appears on the outputs one clock after the edge that takes the triggering command. It then holds until the next search result or reset.
- R8: A search of Valid entries is started by command 1 (load comparand from `op_data`), command 2 (load mask 1), command 3 (load mask 2) and command 4 (load control from `op_data[6:0]`).
- R9: Command 6 rotates the comparand left by one bit, and command 7 rotates it right by one bit. Neither command starts a search.
- R10: `full` is 1 exactly when no entry is Empty. `free_addr` is the lowest Empty index, or 0 when the array is full. Both follow entry writes with no delay beyond the write edge.
- R11: Command 8 writes `op_data` and `op_tag` to `op_addr`. Command 9 writes them to `free_addr`, and is ignored when `full` is 1. Command 10 writes them to the current `hit_addr`, and is ignored when `hit` is 0.
- R12: Control bits [6:5] choose the write mask, with the same codes as R4. Where the selected mask bit is 1, an entry write leaves that data bit unchanged. The tag is always written.
- R13: `rd_data` and `rd_tag` show the entry at `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command strobe for this cycle |
| op_code | input | 4 | Command code |
| op_addr | input | 4 | Absolute write address |
| op_data | input | 64 | Data for a load or an entry write |
| op_tag | input | 2 | Tag for an entry write, or the target tag of a forced search |
| rd_addr | input | 4 | Read address |
| rd_data | output | 64 | Entry data at `rd_addr` |
| rd_tag | output | 2 | Entry tag at `rd_addr` |
| hit | output | 1 | At least one entry qualified in the last search |
| multi_hit | output | 1 | More than one entry qualified in the last search |
| hit_addr | output | 4 | Lowest qualifying index from the last search |
| full | output | 1 | No Empty entry remains |
| free_addr | output | 4 | Lowest Empty index |

## Verification
The properties assume that at most one command arrives per cycle, and that `op_code` carries only the defined codes 0 to 10. The bench drives one command at a time from a task and keeps `op_valid` low otherwise. The status-hold and ignored-write properties also assume that nothing outside a search can change the result registers, and that entry tags change only through the three write commands. Every stimulus command is one of these legal codes.

// File: rtl/cam_pkg.sv
package cam_pkg;

    parameter int SEG_W    = 16;
    parameter int NSEG     = 4;
    parameter int WORD_W   = SEG_W * NSEG;
    parameter int SEGSEL_W = $clog2(NSEG);

    typedef enum logic [1:0] {
        VT_EMPTY = 2'd0,
        VT_VALID = 2'd1,
        VT_SKIP  = 2'd2,
        VT_RAM   = 2'd3
    } vtag_e;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_LD_CMP  = 4'd1,
        OP_LD_MK1  = 4'd2,
        OP_LD_MK2  = 4'd3,
        OP_LD_CTRL = 4'd4,
        OP_SEARCH  = 4'd5,
        OP_ROT_L   = 4'd6,
        OP_ROT_R   = 4'd7,
        OP_WR_ABS  = 4'd8,
        OP_WR_FREE = 4'd9,
        OP_WR_HIT  = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        MS_NONE = 2'd0,
        MS_MK1  = 2'd1,
        MS_MK2  = 2'd2,
        MS_OFF  = 2'd3
    } msel_e;

    // packed: wsel occupies the top bits, rem_segs the bottom bits
    typedef struct packed {
        msel_e                 wsel;
        msel_e                 csel;
        logic                  rem_low;
        logic [SEGSEL_W-1:0]   rem_segs;
    } ctrl_t;

    parameter int CTRL_W = $bits(ctrl_t);

    // bits of the word that take part in a compare
    function automatic logic [WORD_W-1:0] field_care(ctrl_t c);
        int skip;
        skip = int'(c.rem_segs) * SEG_W;
        for (int b = 0; b < WORD_W; b++) begin
            field_care[b] = c.rem_low ? (b >= skip) : (b < WORD_W - skip);
        end
    endfunction

    function automatic logic [WORD_W-1:0] pick_mask(msel_e s,
                                                    logic [WORD_W-1:0] m1,
                                                    logic [WORD_W-1:0] m2);
        case (s)
            MS_MK1:  pick_mask = m1;
            MS_MK2:  pick_mask = m2;
            default: pick_mask = '0;
        endcase
    endfunction

    function automatic logic starts_search(op_e op);
        return (op == OP_LD_CMP) || (op == OP_LD_MK1) || (op == OP_LD_MK2) ||
               (op == OP_LD_CTRL) || (op == OP_SEARCH);
    endfunction

endpackage

// File: rtl/cam_prio.sv
module cam_prio #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cam_regs.sv
module cam_regs
    import cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  op_e               op,
    input  logic [WORD_W-1:0] op_data,
    input  vtag_e             op_tag,
    output logic [WORD_W-1:0] cmp,
    output logic [WORD_W-1:0] mk1,
    output logic [WORD_W-1:0] mk2,
    output ctrl_t             ctrl,
    output logic              srch_req,
    output vtag_e             srch_tag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp      <= '0;
            mk1      <= '0;
            mk2      <= '0;
            ctrl     <= '0;
            srch_req <= 1'b0;
            srch_tag <= VT_VALID;
        end else begin
            srch_req <= op_valid && starts_search(op);
            srch_tag <= (op == OP_SEARCH) ? op_tag : VT_VALID;
            if (op_valid) begin
                case (op)
                    OP_LD_CMP:  cmp  <= op_data;
                    OP_LD_MK1:  mk1  <= op_data;
                    OP_LD_MK2:  mk2  <= op_data;
                    OP_LD_CTRL: ctrl <= ctrl_t'(op_data[CTRL_W-1:0]);
                    OP_ROT_L:   cmp  <= {cmp[WORD_W-2:0], cmp[WORD_W-1]};
                    OP_ROT_R:   cmp  <= {cmp[0], cmp[WORD_W-1:1]};
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cam_store.sv
module cam_store
    import cam_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] wr_keep,
    input  vtag_e             wr_tag,
    input  logic [WORD_W-1:0] key,
    input  logic [WORD_W-1:0] care,
    input  vtag_e             want,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output vtag_e             rd_tag,
    output logic [DEPTH-1:0]  hit_vec,
    output logic [DEPTH-1:0]  empty_vec
);
    logic [WORD_W-1:0] mem [DEPTH];
    vtag_e             tag [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
                tag[i] <= VT_EMPTY;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= (mem[wr_addr] & wr_keep) | (wr_data & ~wr_keep);
            tag[wr_addr] <= wr_tag;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        assign hit_vec[g]   = (tag[g] == want) && (((mem[g] ^ key) & care) == '0);
        assign empty_vec[g] = (tag[g] == VT_EMPTY);
    end

    assign rd_data = mem[rd_addr];
    assign rd_tag  = tag[rd_addr];
endmodule

// File: rtl/cam_assoc.sv
module cam_assoc
    import cam_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [AW-1:0]     op_addr,
    input  logic [WORD_W-1:0] op_data,
    input  logic [1:0]        op_tag,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [1:0]        rd_tag,
    output logic              hit,
    output logic              multi_hit,
    output logic [AW-1:0]     hit_addr,
    output logic              full,
    output logic [AW-1:0]     free_addr
);
    op_e               op;
    vtag_e             in_tag;
    vtag_e             out_tag;
    logic [WORD_W-1:0] cmp, mk1, mk2, care;
    ctrl_t             ctrl;
    logic              srch_req;
    vtag_e             srch_tag;
    logic [DEPTH-1:0]  hit_vec, empty_vec;
    logic              any_hit, any_free;
    logic [AW-1:0]     first_hit, first_free;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic              st_hit, st_multi;
    logic [AW-1:0]     st_addr;

    assign op     = op_e'(op_code);
    assign in_tag = vtag_e'(op_tag);

    cam_regs u_regs (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op),
        .op_data(op_data), .op_tag(in_tag),
        .cmp(cmp), .mk1(mk1), .mk2(mk2), .ctrl(ctrl),
        .srch_req(srch_req), .srch_tag(srch_tag)
    );

    assign care = field_care(ctrl) & ~pick_mask(ctrl.csel, mk1, mk2);

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = op_addr;
        if (op_valid) begin
            case (op)
                OP_WR_ABS:  wr_en = 1'b1;
                OP_WR_FREE: begin wr_en = any_free; wr_addr = first_free; end
                OP_WR_HIT:  begin wr_en = st_hit;   wr_addr = st_addr;    end
                default: ;
            endcase
        end
    end

    cam_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(op_data),
        .wr_keep(pick_mask(ctrl.wsel, mk1, mk2)), .wr_tag(in_tag),
        .key(cmp), .care(care), .want(srch_tag),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_tag(out_tag),
        .hit_vec(hit_vec), .empty_vec(empty_vec)
    );

    cam_prio #(.N(DEPTH)) u_hit_enc  (.vec(hit_vec),   .found(any_hit),  .idx(first_hit));
    cam_prio #(.N(DEPTH)) u_free_enc (.vec(empty_vec), .found(any_free), .idx(first_free));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_hit   <= 1'b0;
            st_multi <= 1'b0;
            st_addr  <= '0;
        end else if (srch_req) begin
            st_hit   <= any_hit;
            st_multi <= |(hit_vec & (hit_vec - DEPTH'(1)));
            st_addr  <= first_hit;
        end
    end

    assign rd_tag    = out_tag;
    assign hit       = st_hit;
    assign multi_hit = st_multi;
    assign hit_addr  = st_addr;
    assign full      = ~any_free;
    assign free_addr = first_free;
endmodule

// File: rtl/cam_chk.sv
module cam_chk
    import cam_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [3:0]       op_code,
    input logic             hit,
    input logic             multi_hit,
    input logic [AW-1:0]    hit_addr,
    input logic             full,
    input logic [AW-1:0]    free_addr,
    input logic             srch_req,
    input logic [DEPTH-1:0] empty_vec
);
    p_multi_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> hit);

    p_status_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !srch_req |=> $stable({hit, multi_hit, hit_addr}));

    p_rot_no_search_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_ROT_L || op_code == OP_ROT_R)) |=> !srch_req);

    p_free_is_empty_r10: assert property (@(posedge clk) disable iff (rst)
        !full |-> empty_vec[free_addr]);

    p_free_lowest_r10: assert property (@(posedge clk) disable iff (rst)
        !full |-> ((empty_vec & ~({DEPTH{1'b1}} << free_addr)) == '0));

    p_full_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_WR_FREE && full) |=> $stable(empty_vec));
endmodule

bind cam_assoc cam_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .hit(hit), .multi_hit(multi_hit), .hit_addr(hit_addr),
    .full(full), .free_addr(free_addr),
    .srch_req(srch_req), .empty_vec(empty_vec)
);

// File: tb/sim_cam_assoc.sv
`timescale 1ns/1ps
module sim_cam_assoc;
    localparam int DEP = 16;
    localparam logic [3:0] C_LDC = 1, C_LM1 = 2, C_LM2 = 3, C_CTL = 4, C_SRC = 5,
                           C_ROL = 6, C_ROR = 7, C_WAB = 8, C_WFR = 9, C_WHT = 10;
    localparam logic [63:0] DA = 64'h1111_2222_3333_4444;
    localparam logic [63:0] DB = 64'hDEAD_BEEF_0000_5555;
    localparam logic [63:0] DE = 64'hCAFE_F00D_1234_5678;

    logic clk = 0, rst = 1, op_valid = 0;
    logic [3:0] op_code = 0, op_addr = 0, rd_addr = 0;
    logic [63:0] op_data = 0;
    logic [1:0] op_tag = 0;
    logic [63:0] rd_data;
    logic [1:0] rd_tag;
    logic hit, multi_hit, full;
    logic [3:0] hit_addr, free_addr;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cam_assoc u0 (.*);

    // ---------- behavioural reference model ----------
    logic [63:0] m_mem [DEP];
    int m_tag [DEP];
    logic [63:0] m_cmp, m_mk1, m_mk2;
    int m_segs, m_low, m_csel, m_wsel, m_ptag, m_haddr;
    bit m_pend, m_hit, m_multi;

    function automatic int m_free();
        for (int i = 0; i < DEP; i++) if (m_tag[i] == 0) return i;
        return -1;
    endfunction

    function automatic logic [63:0] m_sel(int s);
        if (s == 1) return m_mk1;
        if (s == 2) return m_mk2;
        return 64'd0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEP; i++) begin m_mem[i] = 0; m_tag[i] = 0; end
            m_cmp = 0; m_mk1 = 0; m_mk2 = 0;
            m_segs = 0; m_low = 0; m_csel = 0; m_wsel = 0;
            m_pend = 0; m_ptag = 1; m_hit = 0; m_multi = 0; m_haddr = 0;
        end else begin
            bit n_hit, n_multi; int n_addr, cnt, tgt; logic [63:0] cm, keep;
            n_hit = m_hit; n_multi = m_multi; n_addr = m_haddr;
            if (m_pend) begin
                cnt = 0; n_addr = 0;
                cm = m_sel(m_csel);
                for (int i = DEP - 1; i >= 0; i--) begin
                    bit ok; ok = (m_tag[i] == m_ptag);
                    for (int b = 0; b < 64; b++) begin
                        bit inf;
                        inf = m_low ? (b >= m_segs * 16) : (b < 64 - m_segs * 16);
                        if (inf && !cm[b] && (m_mem[i][b] != m_cmp[b])) ok = 0;
                    end
                    if (ok) begin cnt++; n_addr = i; end
                end
                n_hit = cnt > 0; n_multi = cnt > 1;
            end
            tgt = -1;
            if (op_valid) begin
                case (op_code)
                    C_LDC: m_cmp = op_data;
                    C_LM1: m_mk1 = op_data;
                    C_LM2: m_mk2 = op_data;
                    C_CTL: begin
                        m_segs = op_data[1:0]; m_low = op_data[2];
                        m_csel = op_data[4:3]; m_wsel = op_data[6:5];
                    end
                    C_ROL: m_cmp = {m_cmp[62:0], m_cmp[63]};
                    C_ROR: m_cmp = {m_cmp[0], m_cmp[63:1]};
                    C_WAB: tgt = op_addr;
                    C_WFR: tgt = m_free();
                    C_WHT: tgt = m_hit ? m_haddr : -1;
                    default: ;
                endcase
            end
            if (tgt >= 0) begin
                keep = m_sel(m_wsel);
                for (int b = 0; b < 64; b++) if (!keep[b]) m_mem[tgt][b] = op_data[b];
                m_tag[tgt] = op_tag;
            end
            m_hit = n_hit; m_multi = n_multi; m_haddr = n_addr;
            m_pend = op_valid && (op_code >= C_LDC && op_code <= C_SRC);
            m_ptag = (op_code == C_SRC) ? op_tag : 1;
        end
    end

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #5;
        if (!rst && !done) begin
            int f; f = m_free();
            chk("R6 hit", hit, m_hit);
            chk("R6 multi_hit", multi_hit, m_multi);
            chk("R6 hit_addr", hit_addr, m_haddr);
            chk("R10 full", full, f < 0);
            chk("R10 free_addr", free_addr, f < 0 ? 0 : f);
            chk("R13 rd_data", rd_data, m_mem[rd_addr]);
            chk("R13 rd_tag", rd_tag, m_tag[rd_addr]);
        end
    end

    task automatic do_op(logic [3:0] c, logic [3:0] a, logic [63:0] d, logic [1:0] t);
        op_valid = 1; op_code = c; op_addr = a; op_data = d; op_tag = t;
        @(posedge clk); #1;
        op_valid = 0; op_code = 0;
        @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic rd_at(logic [3:0] a, string tag, logic [63:0] d, logic [1:0] t);
        rd_addr = a; #1;
        chk(tag, rd_data, d);
        chk(tag, rd_tag, t);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, while still in reset
        chk("R1 hit", hit, 0); chk("R1 multi", multi_hit, 0);
        chk("R1 full", full, 0); chk("R1 free", free_addr, 0);
        rd_at(4'd5, "R1 entry", 0, 0);
        rst = 0;
        settle();

        do_op(C_WAB, 0, DA, 1);
        do_op(C_WAB, 1, DA, 1);
        do_op(C_WAB, 2, DB, 2);
        do_op(C_WAB, 3, DA, 0);
        chk("R10 free after writes", free_addr, 3);
        rd_at(4'd2, "R11 abs write", DB, 2);

        do_op(C_LDC, 0, DA, 0);
        chk("R7 not yet updated", hit, 0);
        settle();
        chk("R8 hit", hit, 1); chk("R6 multi", multi_hit, 1); chk("R6 lowest", hit_addr, 0);

        do_op(C_LDC, 0, DB, 0); settle();
        chk("R2 skip excluded", hit, 0);
        do_op(C_SRC, 0, 0, 2); settle();
        chk("R3 skip hit", hit, 1); chk("R3 addr", hit_addr, 2); chk("R3 single", multi_hit, 0);
        do_op(C_LDC, 0, DA, 0); settle();
        do_op(C_SRC, 0, 0, 0); settle();
        chk("R3 empty type", hit_addr, 3); chk("R3 empty single", multi_hit, 0);

        do_op(C_LDC, 0, DA ^ 64'hFF, 0); settle();
        chk("R4 no mask miss", hit, 0);
        do_op(C_LM1, 0, 64'hFF, 0); settle();
        chk("R8 mask load search, unselected", hit, 0);
        do_op(C_CTL, 0, 64'h08, 0); settle();
        chk("R4 masked hit", hit, 1); chk("R4 addr", hit_addr, 0);

        do_op(C_CTL, 0, 64'h03, 0);
        do_op(C_LDC, 0, 64'h9999_9999_9999_4444, 0); settle();
        chk("R5 low field hit", hit, 1); chk("R5 multi", multi_hit, 1);
        do_op(C_CTL, 0, 64'h07, 0); settle();
        chk("R5 high field miss", hit, 0);
        do_op(C_CTL, 0, 64'h04, 0); settle();
        chk("R5 full width miss", hit, 0);
        do_op(C_CTL, 0, 64'h00, 0); settle();

        do_op(C_LDC, 0, {DA[62:0], DA[63]}, 0); settle();
        chk("R9 rotated miss", hit, 0);
        do_op(C_ROR, 0, 0, 0); settle();
        chk("R9 no search", hit, 0);
        do_op(C_SRC, 0, 0, 1); settle();
        chk("R9 rotate back hit", hit, 1);
        do_op(C_ROL, 0, 0, 0);
        do_op(C_ROR, 0, 0, 0);
        do_op(C_SRC, 0, 0, 1); settle();
        chk("R9 round trip", hit_addr, 0);

        do_op(C_WHT, 0, DE, 1);
        rd_at(4'd0, "R11 hit write", DE, 1);

        do_op(C_LM2, 0, 64'h0000_0000_FFFF_FFFF, 0);
        do_op(C_CTL, 0, 64'h40, 0);
        do_op(C_WAB, 1, 64'hFFFF_FFFF_FFFF_FFFF, 3);
        rd_at(4'd1, "R12 protected", 64'hFFFF_FFFF_3333_4444, 3);
        do_op(C_CTL, 0, 64'h00, 0);

        do_op(C_WFR, 0, 64'h77, 1);
        rd_at(4'd3, "R11 free write", 64'h77, 1);
        chk("R10 free moved", free_addr, 4);
        for (int i = 4; i < DEP; i++) do_op(C_WFR, 0, 64'(i), 2);
        chk("R10 full", full, 1); chk("R10 free zero", free_addr, 0);
        do_op(C_WFR, 0, 64'h55, 0);
        rd_at(4'd0, "R11 full ignored", DE, 1);
        chk("R11 still full", full, 1);

        do_op(C_LDC, 0, 64'h1, 0); settle();
        chk("R6 miss", hit, 0); chk("R6 miss addr", hit_addr, 0);
        do_op(C_WHT, 0, 64'h99, 0);
        rd_at(4'd0, "R11 no-hit ignored", DE, 1);

        rst = 1; settle(); settle();
        chk("R1 re-reset full", full, 0);
        rd_at(4'd0, "R1 re-reset entry", 0, 0);
        rst = 0; settle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule